// File: doc/BRIEF.md
# Residue-Coded Address Index Unit

This block is the address arithmetic of a control processor whose addresses travel in an error-detecting form. Each address is a 16-bit binary value with a 4-bit check symbol attached. The symbol is the complement of the address residue modulo 15. The unit holds one sequence register and two index registers, all stored in this coded form. It forms indexed addresses, steps the sequence register, and loads the sequence register on a jump, either always or when a stored result condition matches.

The check symbol is never rebuilt from a finished address. Every arithmetic result carries its symbol forward using modulo-15 addition of the operand symbols. A wrap of the 16-bit sum removes 2^16, which is 1 modulo 15, so the symbol then takes an extra +1. A separate residue checker re-validates every result. It raises a flag when a coded word does not close to zero modulo 15. An operand that was already corrupted is therefore reported, not silently re-encoded.

The surrounding control logic issues one operation per cycle with a register select and a coded input word. It reads the coded result and the flag one cycle later.

Top module: `addr_index_unit`

## Requirements
- R1: A coded word puts the address in bits 15:0 and the check symbol in bits 19:16. The canonical symbol is 15 minus (address mod 15), which gives 15 for a residue of 0. While reset is held, resValid and chkErr are 0 and resCode is all zeros. After reset, every register reads back coded zero (0xF0000).
- R2: The operation codes are: 0 idle, 1 load sequence, 2 load index, 3 index add, 4 step, 5 jump, 6 set condition, 7 read. Load sequence and load index echo inCode as the result and store it. regSel 0 or 1 selects an index register, and a value of 2 or more selects the sequence register. A load-index with regSel of 2 or more stores nothing. Read returns the selected register.
- R3: Index add returns (inCode address + selected register address) mod 2^16. The check symbol is the modulo-15 sum of both symbols, plus 1 when the 16-bit addition carries out. For valid operands this equals the canonical symbol of the sum. No register changes.
- R4: Step writes the sequence address + 1 (mod 2^16) back, with symbol + 14 modulo 15 and the same carry correction. It returns the new value. 0xFFFF wraps to coded zero.
- R5: Jump loads the sequence register with inCode when ccNib equals the stored condition or when ccNib is 1111. Otherwise it steps as in R4. The result is the new sequence value.
- R6: The condition codes are positive 1001, zero 0101 and negative 0110, and reset leaves zero (0101). Set condition stores ccNib only if it has exactly two ones. Any other nibble leaves the stored condition unchanged.
- R7: chkErr is 1 with a result exactly when the result is not a validly coded address. This covers an echoed invalid input and arithmetic on an invalid operand.
- R8: Results appear on the cycle after the operation. resValid is 1 after operations 1 to 5 and 7, and 0 after idle, set condition, or opValid low.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation present this cycle |
| opSel | input | 3 | Operation code (R2) |
| regSel | input | 2 | Register select: 0, 1 index; 2 or more sequence |
| inCode | input | 20 | Coded input address |
| ccNib | input | 4 | Condition to store (set) or to test (jump) |
| resCode | output | 20 | Coded result, held between results |
| resValid | output | 1 | Result produced by the previous cycle's operation |
| chkErr | output | 1 | Result failed the residue check |

## Verification
The bound checker watches the result timing on every cycle. It checks that idle and set-condition cycles yield no result, that the flag never appears without a result, and that loads echo their input. It also checks that back-to-back steps produce consecutive addresses, and that a canonically coded load never raises the flag. The exact values of carried check symbols through index carries, the 0xFFFF wrap, conditional jump decisions against the stored condition, ignored loads and ignored condition nibbles, and error propagation from a corrupted operand depend on held state. The bench's scenarios and reference model show these.

// File: rtl/aiu_pkg.sv
package aiu_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LDSEQ = 3'd1,
    OP_LDIDX = 3'd2,
    OP_INDEX = 3'd3,
    OP_STEP  = 3'd4,
    OP_JUMP  = 3'd5,
    OP_SETCC = 3'd6,
    OP_READ  = 3'd7
  } aiuOp_e;

  typedef enum logic [1:0] {
    SRC_IN  = 2'd0,
    SRC_SUM = 2'd1,
    SRC_SEQ = 2'd2,
    SRC_REG = 2'd3
  } resSrc_e;

  typedef struct packed {
    logic    seqWr;
    logic    seqFromIn;
    logic    idxWr;
    logic    ccWr;
    resSrc_e resSrc;
    logic    resVal;
  } aiuStrobe_t;

  localparam logic [3:0] CC_ZERO = 4'b0101;

  // one's-complement (end-around carry) add of two mod-15 symbols
  function automatic logic [3:0] mod15Add(input logic [3:0] x, input logic [3:0] y);
    logic [4:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[3:0] + {3'b000, s[4]};
  endfunction

endpackage

// File: rtl/aiu_coded_add.sv
module aiu_coded_add #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W+3:0] aCode,
  input  logic [ADDR_W+3:0] bCode,
  output logic [ADDR_W+3:0] sumCode
);
  import aiu_pkg::*;

  logic [ADDR_W:0] wideSum;
  logic [3:0]      symSum;
  logic [3:0]      symFix;

  always_comb begin
    wideSum = {1'b0, aCode[ADDR_W-1:0]} + {1'b0, bCode[ADDR_W-1:0]};
    symSum  = mod15Add(aCode[ADDR_W+3:ADDR_W], bCode[ADDR_W+3:ADDR_W]);
    // dropping 2^ADDR_W lowers the residue by one, so the symbol gains one
    symFix  = mod15Add(symSum, {3'b000, wideSum[ADDR_W]});
    sumCode = {symFix, wideSum[ADDR_W-1:0]};
  end

endmodule

// File: rtl/aiu_code_check.sv
module aiu_code_check #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W+3:0] code,
  output logic              codeOk
);
  import aiu_pkg::*;

  localparam int NIBS = ADDR_W / 4;

  logic [3:0] resid;

  always_comb begin
    resid = 4'h0;
    for (int n = 0; n < NIBS; n++) begin
      resid = mod15Add(resid, code[n*4 +: 4]);
    end
    codeOk = (mod15Add(resid, code[ADDR_W+3:ADDR_W]) == 4'hF);
  end

endmodule

// File: rtl/aiu_ctrl.sv
module aiu_ctrl #(
  parameter int NUM_IDX = 2,
  parameter int SEL_W   = 2
) (
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [3:0]        ccNib,
  input  logic [3:0]        ccCur,
  output aiu_pkg::aiuStrobe_t strb
);
  import aiu_pkg::*;

  aiuOp_e op;
  logic   condHit;
  logic   ccLegal;
  logic   idxTarget;

  assign op        = aiuOp_e'(opSel);
  assign condHit   = (ccNib == 4'hF) || (ccNib == ccCur);
  assign ccLegal   = ($countones(ccNib) == 2);
  assign idxTarget = (int'(regSel) < NUM_IDX);

  always_comb begin
    strb = '0;
    strb.resSrc = SRC_IN;
    if (opValid) begin
      unique case (op)
        OP_LDSEQ: begin
          strb.seqWr     = 1'b1;
          strb.seqFromIn = 1'b1;
          strb.resVal    = 1'b1;
        end
        OP_LDIDX: begin
          strb.idxWr  = idxTarget;
          strb.resVal = 1'b1;
        end
        OP_INDEX: begin
          strb.resSrc = SRC_SUM;
          strb.resVal = 1'b1;
        end
        OP_STEP: begin
          strb.seqWr  = 1'b1;
          strb.resSrc = SRC_SEQ;
          strb.resVal = 1'b1;
        end
        OP_JUMP: begin
          strb.seqWr     = 1'b1;
          strb.seqFromIn = condHit;
          strb.resSrc    = SRC_SEQ;
          strb.resVal    = 1'b1;
        end
        OP_SETCC: begin
          strb.ccWr = ccLegal;
        end
        OP_READ: begin
          strb.resSrc = SRC_REG;
          strb.resVal = 1'b1;
        end
        default: begin
          strb.resVal = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/aiu_datapath.sv
module aiu_datapath #(
  parameter int ADDR_W  = 16,
  parameter int NUM_IDX = 2,
  parameter int SEL_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  aiu_pkg::aiuStrobe_t strb,
  input  logic [SEL_W-1:0]    regSel,
  input  logic [ADDR_W+3:0]   inCode,
  input  logic [3:0]          ccNib,
  output logic [3:0]          ccCur,
  output logic [ADDR_W+3:0]   resCode,
  output logic                resValid,
  output logic                chkErr
);
  import aiu_pkg::*;

  localparam int CODE_W = ADDR_W + 4;
  localparam logic [CODE_W-1:0] CODED_ZERO = {4'hF, {ADDR_W{1'b0}}};
  localparam logic [CODE_W-1:0] CODED_ONE  = {4'hE, {{(ADDR_W-1){1'b0}}, 1'b1}};

  logic [CODE_W-1:0] seqReg;
  logic [CODE_W-1:0] idxReg [NUM_IDX];
  logic [3:0]        ccReg;
  logic [CODE_W-1:0] opnd;
  logic [CODE_W-1:0] idxSum;
  logic [CODE_W-1:0] seqInc;
  logic [CODE_W-1:0] seqNew;
  logic [CODE_W-1:0] resNext;
  logic              resOk;

  // operand select: index register by number, sequence register otherwise
  always_comb begin
    opnd = seqReg;
    for (int i = 0; i < NUM_IDX; i++) begin
      if (regSel == SEL_W'(i)) opnd = idxReg[i];
    end
  end

  aiu_coded_add #(.ADDR_W(ADDR_W)) u_idxAdd (
    .aCode  (inCode),
    .bCode  (opnd),
    .sumCode(idxSum)
  );

  aiu_coded_add #(.ADDR_W(ADDR_W)) u_incAdd (
    .aCode  (seqReg),
    .bCode  (CODED_ONE),
    .sumCode(seqInc)
  );

  assign seqNew = strb.seqFromIn ? inCode : seqInc;

  always_comb begin
    unique case (strb.resSrc)
      SRC_IN:  resNext = inCode;
      SRC_SUM: resNext = idxSum;
      SRC_SEQ: resNext = seqNew;
      default: resNext = opnd;
    endcase
  end

  aiu_code_check #(.ADDR_W(ADDR_W)) u_resChk (
    .code  (resNext),
    .codeOk(resOk)
  );

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idxReg[g] <= CODED_ZERO;
      end else if (strb.idxWr && (regSel == SEL_W'(g))) begin
        idxReg[g] <= inCode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqReg <= CODED_ZERO;
      ccReg  <= CC_ZERO;
    end else begin
      if (strb.seqWr) seqReg <= seqNew;
      if (strb.ccWr)  ccReg  <= ccNib;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resCode  <= '0;
      resValid <= 1'b0;
      chkErr   <= 1'b0;
    end else begin
      resValid <= strb.resVal;
      chkErr   <= strb.resVal && !resOk;
      if (strb.resVal) resCode <= resNext;
    end
  end

  assign ccCur = ccReg;

endmodule

// File: rtl/addr_index_unit.sv
module addr_index_unit #(
  parameter int ADDR_W  = 16,
  parameter int NUM_IDX = 2,
  parameter int SEL_W   = $clog2(NUM_IDX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W+3:0] inCode,
  input  logic [3:0]        ccNib,
  output logic [ADDR_W+3:0] resCode,
  output logic              resValid,
  output logic              chkErr
);
  import aiu_pkg::*;

  aiuStrobe_t strb;
  logic [3:0] ccCur;

  aiu_ctrl #(.NUM_IDX(NUM_IDX), .SEL_W(SEL_W)) u_ctrl (
    .opValid(opValid),
    .opSel  (opSel),
    .regSel (regSel),
    .ccNib  (ccNib),
    .ccCur  (ccCur),
    .strb   (strb)
  );

  aiu_datapath #(.ADDR_W(ADDR_W), .NUM_IDX(NUM_IDX), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regSel  (regSel),
    .inCode  (inCode),
    .ccNib   (ccNib),
    .ccCur   (ccCur),
    .resCode (resCode),
    .resValid(resValid),
    .chkErr  (chkErr)
  );

endmodule

// File: rtl/aiu_checker.sv
module aiu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opSel,
  input logic [ADDR_W+3:0] inCode,
  input logic [ADDR_W+3:0] resCode,
  input logic              resValid,
  input logic              chkErr
);
  import aiu_pkg::*;

  function automatic bit canonical(input logic [ADDR_W+3:0] c);
    int r;
    r = int'(c[ADDR_W-1:0]) % 15;
    return c[ADDR_W+3:ADDR_W] == 4'(15 - r);
  endfunction

  logic quietOp;
  logic loadOp;
  logic stepOp;
  assign quietOp = !opValid || (opSel == OP_NOP) || (opSel == OP_SETCC);
  assign loadOp  = opValid && ((opSel == OP_LDSEQ) || (opSel == OP_LDIDX));
  assign stepOp  = opValid && (opSel == OP_STEP);

  // R8: idle and set-condition cycles produce no result
  p_quiet_no_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    quietOp |=> !resValid);

  // R8: every result-bearing operation yields a result next cycle
  p_op_gives_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    !quietOp |=> resValid);

  // R7: the flag only accompanies a result
  p_err_with_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    chkErr |-> resValid);

  // R2: loads echo the input word
  p_load_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadOp |=> (resCode == $past(inCode)));

  // R4: consecutive steps give consecutive addresses
  p_step_chain_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stepOp && $past(stepOp)) |=>
      (resCode[ADDR_W-1:0] == ADDR_W'($past(resCode[ADDR_W-1:0]) + 1'b1)));

  // R7: a canonically coded sequence load is never flagged
  p_clean_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_LDSEQ) && canonical(inCode)) |=> !chkErr);

endmodule

bind addr_index_unit aiu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opSel   (opSel),
  .inCode  (inCode),
  .resCode (resCode),
  .resValid(resValid),
  .chkErr  (chkErr)
);

// File: tb/sim_addr_index_unit.sv
module sim_addr_index_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [1:0]  regSel = 2'd0;
  logic [19:0] inCode = 20'd0;
  logic [3:0]  ccNib = 4'd0;
  logic [19:0] resCode;
  logic        resValid;
  logic        chkErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  addr_index_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .regSel(regSel),
    .inCode(inCode), .ccNib(ccNib), .resCode(resCode), .resValid(resValid), .chkErr(chkErr)
  );

  // stimulus row: {op[2:0], regSel[1:0], nibble[3:0], raw address[15:0]}
  localparam int NV = 25;
  localparam logic [24:0] VEC [NV] = '{
    {3'd2, 2'd0, 4'h0, 16'h1234},  // load idx0
    {3'd2, 2'd1, 4'h0, 16'hFFFF},  // load idx1
    {3'd7, 2'd0, 4'h0, 16'h0000},  // read idx0
    {3'd7, 2'd1, 4'h0, 16'h0000},  // read idx1
    {3'd1, 2'd0, 4'h0, 16'hFFFE},  // load seq
    {3'd4, 2'd0, 4'h0, 16'h0000},  // step -> FFFF
    {3'd4, 2'd0, 4'h0, 16'h0000},  // step wraps -> 0000
    {3'd3, 2'd1, 4'h0, 16'h0002},  // FFFF + 0002 carries
    {3'd3, 2'd0, 4'h0, 16'h0100},  // 1234 + 0100
    {3'd3, 2'd2, 4'h0, 16'hABCD},  // seq + ABCD
    {3'd2, 2'd3, 4'h0, 16'h5555},  // load to non-index select: ignored
    {3'd7, 2'd0, 4'h0, 16'h0000},
    {3'd7, 2'd1, 4'h0, 16'h0000},
    {3'd6, 2'd0, 4'h9, 16'h0000},  // condition positive
    {3'd5, 2'd0, 4'h9, 16'h4000},  // jump taken
    {3'd5, 2'd0, 4'h6, 16'h8000},  // jump not taken -> step
    {3'd5, 2'd0, 4'hF, 16'h7FFF},  // unconditional
    {3'd4, 2'd0, 4'h0, 16'h0000},
    {3'd2, 2'd0, 4'h0, 16'hFFF1},
    {3'd3, 2'd0, 4'h0, 16'h8765},  // carries
    {3'd6, 2'd0, 4'h7, 16'h0000},  // weight three: ignored
    {3'd5, 2'd0, 4'h9, 16'h0100},  // still positive -> taken
    {3'd6, 2'd0, 4'h6, 16'h0000},  // negative
    {3'd5, 2'd0, 4'h9, 16'h0200},  // not taken
    {3'd7, 2'd2, 4'h0, 16'h0000}   // read seq
  };

  int seqM;
  int idxM [2];
  logic [3:0] ccM;

  function automatic logic [19:0] code(input int a);
    logic [3:0] c;
    c = 4'(15 - (a % 15));
    return {c, 16'(a)};
  endfunction

  function automatic int selM(input int rs);
    return (rs < 2) ? idxM[rs] : seqM;
  endfunction

  task automatic check(input string req, input string what, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] rs, input logic [3:0] nib, input logic [19:0] c);
    opValid = 1'b1;
    opSel   = op;
    regSel  = rs;
    ccNib   = nib;
    inCode  = c;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    seqM = 0; idxM[0] = 0; idxM[1] = 0; ccM = 4'b0101;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check("R1", "resValid in reset", {19'd0, resValid}, 20'd0);
    check("R1", "chkErr in reset", {19'd0, chkErr}, 20'd0);
    check("R1", "resCode in reset", resCode, 20'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: registers come out of reset as coded zero
    issue(3'd7, 2'd2, 4'h0, 20'd0);
    check("R1", "seq after reset", resCode, 20'hF0000);
    issue(3'd7, 2'd1, 4'h0, 20'd0);
    check("R1", "idx1 after reset", resCode, 20'hF0000);
    // R6: reset condition is zero (0101), so this jump is taken
    issue(3'd5, 2'd0, 4'h5, code(16'h0300));
    seqM = 16'h0300;
    check("R6", "jump on reset condition", resCode, code(seqM));

    for (int k = 0; k < NV; k++) begin
      logic [2:0] op;
      logic [1:0] rs;
      logic [3:0] nib;
      int a;
      int expA;
      bit expV;
      string tag;
      op = VEC[k][24:22]; rs = VEC[k][21:20]; nib = VEC[k][19:16]; a = int'(VEC[k][15:0]);
      expV = 1'b1; expA = 0; tag = "R2";
      case (op)
        3'd1: begin seqM = a; expA = a; tag = "R2"; end
        3'd2: begin if (rs < 2) idxM[rs] = a; expA = a; tag = "R2"; end
        3'd3: begin expA = (a + selM(rs)) % 65536; tag = "R3"; end
        3'd4: begin seqM = (seqM + 1) % 65536; expA = seqM; tag = "R4"; end
        3'd5: begin
          if (nib == 4'hF || nib == ccM) seqM = a; else seqM = (seqM + 1) % 65536;
          expA = seqM; tag = "R5";
        end
        3'd6: begin if ($countones(nib) == 2) ccM = nib; expV = 1'b0; tag = "R6"; end
        3'd7: begin expA = selM(rs); tag = "R2"; end
        default: expV = 1'b0;
      endcase
      issue(op, rs, nib, code(a));
      check("R8", $sformatf("row %0d resValid", k), {19'd0, resValid}, {19'd0, expV});
      if (expV) begin
        check(tag, $sformatf("row %0d resCode", k), resCode, code(expA));
        check("R7", $sformatf("row %0d chkErr", k), {19'd0, chkErr}, 20'd0);
      end
    end

    // R7: invalid input echoed and flagged
    issue(3'd1, 2'd0, 4'h0, {4'h0, 16'h0005});
    check("R7", "bad load flag", {19'd0, chkErr}, 20'd1);
    check("R2", "bad load echo", resCode, {4'h0, 16'h0005});
    // R7: step on a corrupted sequence stays flagged
    issue(3'd4, 2'd0, 4'h0, 20'd0);
    check("R7", "step on bad seq", {19'd0, chkErr}, 20'd1);
    // R7: index add with a corrupted input is flagged
    issue(3'd3, 2'd0, 4'h0, {4'h3, 16'h0005});
    check("R7", "index on bad input", {19'd0, chkErr}, 20'd1);
    // R8: idle gives no result
    issue(3'd0, 2'd0, 4'h0, 20'd0);
    check("R8", "idle resValid", {19'd0, resValid}, 20'd0);
    // R7: a good load clears the flag
    issue(3'd1, 2'd0, 4'h0, code(16'h2222));
    check("R7", "good load flag", {19'd0, chkErr}, 20'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule